// File: doc/BRIEF.md
# Resistive Cell Write-Verify Sequencer

This block drives one program-and-verify operation on a single resistive memory cell. The operation is either a reset, which moves the cell to high resistance, or a set, which moves it to low resistance. In each trial the block sends one program pulse command to an external pulse driver, then one low-voltage read request, and then takes a pass/fail verdict from an external resistance comparator. It repeats trials until the cell passes or the trial limit is used up. It then reports how many trials ran, the summed width of all the pulses it applied, and whether the cell failed.

In a reset, the pulse voltage and polarity stay fixed and only the width changes from one trial to the next. The width can grow by a constant step, or by a step that gets larger with the trial index, so a cell that is hard to switch is pushed harder sooner. In a set, the width stays fixed and the voltage rises by one code per trial. Widths are counted in 20 ns ticks and voltages in 0.1 V codes.

The pulse, read and verdict exchanges are each a valid/ready handshake. The block waits on each one without limit. While it holds a pulse or read request that has not been accepted, it keeps the request asserted and keeps the pulse fields stable; the far side applies back-pressure by holding ready low. The verdict is taken only when both `cmp_valid` and `cmp_ready` are high.

Top module: `wv_seq`

## Requirements
- R1: After reset, `done`, `fail`, `pulse_valid`, `read_valid` and `cmp_ready` are 0, and `trials` and `total_width` are 0.
- R2: Every reset pulse has `pulse_neg`=1 and `pulse_volt`=15 (-1.5 V). The first reset pulse has `pulse_width` equal to `init_code`.
- R3: In a reset with `accel`=0, each retry pulse is 2 ticks (40 ns) wider than the previous pulse.
- R4: In a reset with `accel`=1, the width going into trial m (m at least 2) grows by 2×(m-1) ticks: +2 into trial 2, +4 into trial 3, +6 into trial 4.
- R5: Every set pulse has `pulse_neg`=0 and `pulse_width`=5 ticks (100 ns). Its `pulse_volt` is `init_code[5:0]` at trial 1 and rises by 1 per later trial.
- R6: Each trial runs in this order: one pulse handshake, then one read handshake, then one verdict handshake. At most one of `pulse_valid`, `read_valid` and `cmp_ready` is high at a time. While a request waits for ready, it and its fields stay unchanged.
- R7: A passing verdict (`cmp_pass`=1) ends the operation. `done` is high for exactly one cycle, `fail`=0, and `trials` equals the number of pulses issued.
- R8: If trial 21 receives a failing verdict, the operation ends with `fail`=1 and `trials`=21, and no 22nd pulse is issued.
- R9: `total_width` is the sum of the `pulse_width` values of all pulses accepted in the operation. It saturates at 4095.
- R10: The pulse width saturates at 255 and the set voltage code saturates at 63. Neither wraps around.
- R11: A `start` raised while an operation is running has no effect on that operation's pulses or results.
- R12: `trials`, `total_width` and `fail` hold their final values after `done` until the next accepted `start`. No request is raised in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| op_set | input | 1 | 1 = set operation, 0 = reset operation |
| accel | input | 1 | Reset width schedule: 1 = growing step, 0 = constant step |
| init_code | input | 8 | Initial width in ticks (reset) or voltage code in bits 5:0 (set) |
| pulse_valid | output | 1 | Pulse command valid |
| pulse_ready | input | 1 | Driver accepts the pulse command |
| pulse_volt | output | 6 | Pulse voltage magnitude, 0.1 V per code |
| pulse_neg | output | 1 | Pulse polarity, 1 = negative |
| pulse_width | output | 8 | Pulse width in 20 ns ticks |
| read_valid | output | 1 | Verify read request valid |
| read_ready | input | 1 | Sense circuit accepts the read request |
| cmp_valid | input | 1 | Comparator verdict valid |
| cmp_ready | output | 1 | Block is waiting for the verdict |
| cmp_pass | input | 1 | Verdict: 1 = cell meets the target resistance |
| done | output | 1 | One-cycle end-of-operation strobe |
| trials | output | 5 | Trials used in the current or last operation |
| total_width | output | 12 | Summed pulse width in ticks |
| fail | output | 1 | Trial limit reached without a pass |

## Verification
A `start` that is sampled at a clock edge raises `pulse_valid` right after that edge. A pulse or read handshake that completes at an edge moves the request to the next stage after that same edge. The verdict accepted at an edge makes `done`, `trials`, `total_width` and `fail` valid in the cycle that follows, and `done` is low again one cycle later. The bench drives all inputs and samples all outputs on falling edges. Its responder stalls each handshake by a varying number of cycles. The bench waits for `done` instead of counting a fixed number of cycles, and it checks that `done` has dropped one falling edge later. Pulse fields are logged as soon as a request appears, so any change while the request stalls is caught by the field comparison.

// File: rtl/wv_pkg.sv
package wv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_READ  = 2'd2,
    ST_SENSE = 2'd3
  } wv_state_e;
endpackage

// File: rtl/wv_step.sv
// Holds the pulse command fields and advances them between trials.
module wv_step #(
  parameter int WIDTH_W     = 8,
  parameter int VOLT_W      = 6,
  parameter int TRIAL_W     = 5,
  parameter int STEP_TICKS  = 2,
  parameter int SET_TICKS   = 5,
  parameter int RESET_VCODE = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  logic               op_set_i,
  input  logic               accel_i,
  input  logic [WIDTH_W-1:0] init_i,
  input  logic [TRIAL_W-1:0] trial_i,
  output logic [WIDTH_W-1:0] width_o,
  output logic [VOLT_W-1:0]  volt_o,
  output logic               neg_o
);
  localparam int STEP_W = WIDTH_W + TRIAL_W;
  localparam logic [STEP_W:0]    WMAX = (STEP_W+1)'({WIDTH_W{1'b1}});
  localparam logic [VOLT_W-1:0]  VMAX = {VOLT_W{1'b1}};

  logic               set_q, accel_q;
  logic [WIDTH_W-1:0] width_q;
  logic [VOLT_W-1:0]  volt_q;
  logic [STEP_W-1:0]  step;
  logic [STEP_W:0]    wsum;
  logic [WIDTH_W-1:0] width_nx;
  logic [VOLT_W-1:0]  volt_nx;

  // step into trial m+1 from trial m: growing schedule uses m, constant uses 1
  always_comb begin
    if (accel_q) step = STEP_W'(STEP_TICKS) * STEP_W'(trial_i);
    else         step = STEP_W'(STEP_TICKS);
    wsum = (STEP_W+1)'(width_q) + (STEP_W+1)'(step);
    width_nx = (wsum > WMAX) ? {WIDTH_W{1'b1}} : wsum[WIDTH_W-1:0];
    volt_nx  = (volt_q == VMAX) ? VMAX : volt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q   <= 1'b0;
      accel_q <= 1'b0;
      width_q <= '0;
      volt_q  <= '0;
    end else if (load) begin
      set_q   <= op_set_i;
      accel_q <= accel_i;
      width_q <= op_set_i ? WIDTH_W'(SET_TICKS) : init_i;
      volt_q  <= op_set_i ? init_i[VOLT_W-1:0] : VOLT_W'(RESET_VCODE);
    end else if (adv) begin
      if (set_q) volt_q  <= volt_nx;
      else       width_q <= width_nx;
    end
  end

  assign width_o = width_q;
  assign volt_o  = volt_q;
  assign neg_o   = ~set_q;
endmodule

// File: rtl/wv_accum.sv
// Saturating sum of accepted pulse widths.
module wv_accum #(
  parameter int WIDTH_W = 8,
  parameter int TOTAL_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               add,
  input  logic [WIDTH_W-1:0] width_i,
  output logic [TOTAL_W-1:0] total_o
);
  localparam logic [TOTAL_W:0] TMAX = {1'b0, {TOTAL_W{1'b1}}};

  logic [TOTAL_W-1:0] total_q;
  logic [TOTAL_W:0]   sum;

  always_comb sum = (TOTAL_W+1)'(total_q) + (TOTAL_W+1)'(width_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     total_q <= '0;
    else if (clear) total_q <= '0;
    else if (add)   total_q <= (sum > TMAX) ? {TOTAL_W{1'b1}} : sum[TOTAL_W-1:0];
  end

  assign total_o = total_q;
endmodule

// File: rtl/wv_ctrl.sv
// Trial sequencing: pulse, read, verdict; pass or limit ends the run.
module wv_ctrl #(
  parameter int MAX_TRIALS = 21,
  parameter int TRIAL_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               pulse_ready,
  input  logic               read_ready,
  input  logic               cmp_valid,
  input  logic               cmp_pass,
  output logic               load,
  output logic               adv,
  output logic               pulse_fire,
  output logic               pulse_valid,
  output logic               read_valid,
  output logic               cmp_ready,
  output logic               done,
  output logic               fail,
  output logic [TRIAL_W-1:0] trials
);
  import wv_pkg::*;

  wv_state_e          st_q, st_nx;
  logic               done_q, fail_q;
  logic [TRIAL_W-1:0] trial_q;
  logic               verdict, at_limit;

  assign verdict  = (st_q == ST_SENSE) && cmp_valid;
  assign at_limit = (trial_q == TRIAL_W'(MAX_TRIALS));

  always_comb begin
    st_nx = st_q;
    load  = 1'b0;
    adv   = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start) begin st_nx = ST_PULSE; load = 1'b1; end
      ST_PULSE: if (pulse_ready) st_nx = ST_READ;
      ST_READ:  if (read_ready)  st_nx = ST_SENSE;
      ST_SENSE: if (cmp_valid) begin
        if (cmp_pass || at_limit) st_nx = ST_IDLE;
        else begin st_nx = ST_PULSE; adv = 1'b1; end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      trial_q <= '0;
    end else begin
      st_q   <= st_nx;
      done_q <= verdict && (cmp_pass || at_limit);
      if (load) begin
        trial_q <= TRIAL_W'(1);
        fail_q  <= 1'b0;
      end else if (verdict) begin
        if (!cmp_pass && at_limit) fail_q  <= 1'b1;
        else if (!cmp_pass)        trial_q <= trial_q + 1'b1;
      end
    end
  end

  assign pulse_valid = (st_q == ST_PULSE);
  assign read_valid  = (st_q == ST_READ);
  assign cmp_ready   = (st_q == ST_SENSE);
  assign pulse_fire  = pulse_valid && pulse_ready;
  assign done        = done_q;
  assign fail        = fail_q;
  assign trials      = trial_q;
endmodule

// File: rtl/wv_seq.sv
module wv_seq #(
  parameter int WIDTH_W     = 8,
  parameter int VOLT_W      = 6,
  parameter int TOTAL_W     = 12,
  parameter int MAX_TRIALS  = 21,
  parameter int STEP_TICKS  = 2,
  parameter int SET_TICKS   = 5,
  parameter int RESET_VCODE = 15,
  localparam int TRIAL_W    = $clog2(MAX_TRIALS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op_set,
  input  logic               accel,
  input  logic [WIDTH_W-1:0] init_code,
  output logic               pulse_valid,
  input  logic               pulse_ready,
  output logic [VOLT_W-1:0]  pulse_volt,
  output logic               pulse_neg,
  output logic [WIDTH_W-1:0] pulse_width,
  output logic               read_valid,
  input  logic               read_ready,
  input  logic               cmp_valid,
  output logic               cmp_ready,
  input  logic               cmp_pass,
  output logic               done,
  output logic [TRIAL_W-1:0] trials,
  output logic [TOTAL_W-1:0] total_width,
  output logic               fail
);
  logic load, adv, pulse_fire;

  wv_ctrl #(.MAX_TRIALS(MAX_TRIALS), .TRIAL_W(TRIAL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pulse_ready(pulse_ready), .read_ready(read_ready),
    .cmp_valid(cmp_valid), .cmp_pass(cmp_pass),
    .load(load), .adv(adv), .pulse_fire(pulse_fire),
    .pulse_valid(pulse_valid), .read_valid(read_valid), .cmp_ready(cmp_ready),
    .done(done), .fail(fail), .trials(trials)
  );

  wv_step #(
    .WIDTH_W(WIDTH_W), .VOLT_W(VOLT_W), .TRIAL_W(TRIAL_W),
    .STEP_TICKS(STEP_TICKS), .SET_TICKS(SET_TICKS), .RESET_VCODE(RESET_VCODE)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .op_set_i(op_set), .accel_i(accel), .init_i(init_code), .trial_i(trials),
    .width_o(pulse_width), .volt_o(pulse_volt), .neg_o(pulse_neg)
  );

  wv_accum #(.WIDTH_W(WIDTH_W), .TOTAL_W(TOTAL_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(load), .add(pulse_fire),
    .width_i(pulse_width), .total_o(total_width)
  );
endmodule

// File: rtl/wv_seq_chk.sv
module wv_seq_chk #(
  parameter int WIDTH_W     = 8,
  parameter int VOLT_W      = 6,
  parameter int TOTAL_W     = 12,
  parameter int MAX_TRIALS  = 21,
  parameter int RESET_VCODE = 15,
  parameter int TRIAL_W     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pulse_valid,
  input logic               pulse_ready,
  input logic [VOLT_W-1:0]  pulse_volt,
  input logic               pulse_neg,
  input logic [WIDTH_W-1:0] pulse_width,
  input logic               read_valid,
  input logic               read_ready,
  input logic               cmp_ready,
  input logic               done,
  input logic [TRIAL_W-1:0] trials,
  input logic [TOTAL_W-1:0] total_width,
  input logic               fail
);
  // R6
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_valid && !pulse_ready |=> pulse_valid && $stable(pulse_width)
      && $stable(pulse_volt) && $stable(pulse_neg));
  // R6
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_valid && !read_ready |=> read_valid);
  // R6
  one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_valid, read_valid, cmp_ready}));
  // R2
  reset_volt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_valid && pulse_neg |-> pulse_volt == VOLT_W'(RESET_VCODE));
  // R7
  done_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  trial_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trials <= TRIAL_W'(MAX_TRIALS));
  // R8
  fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> trials == TRIAL_W'(MAX_TRIALS));
  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !pulse_valid || ($stable(total_width) && $stable(fail)) || trials == TRIAL_W'(1));
endmodule

bind wv_seq wv_seq_chk #(
  .WIDTH_W(WIDTH_W), .VOLT_W(VOLT_W), .TOTAL_W(TOTAL_W),
  .MAX_TRIALS(MAX_TRIALS), .RESET_VCODE(RESET_VCODE), .TRIAL_W(TRIAL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_valid(pulse_valid), .pulse_ready(pulse_ready),
  .pulse_volt(pulse_volt), .pulse_neg(pulse_neg), .pulse_width(pulse_width),
  .read_valid(read_valid), .read_ready(read_ready), .cmp_ready(cmp_ready),
  .done(done), .trials(trials), .total_width(total_width), .fail(fail)
);

// File: tb/wv_seq_bench.sv
module wv_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_set = 1'b0, accel = 1'b0;
  logic [7:0] init_code = '0;
  logic pulse_valid, pulse_ready, pulse_neg, read_valid, read_ready;
  logic cmp_valid, cmp_ready, cmp_pass, done, fail;
  logic [5:0] pulse_volt;
  logic [7:0] pulse_width;
  logic [4:0] trials;
  logic [11:0] total_width;

  int checks = 0, fails = 0, cycles = 0;
  int pcount = 0, rcount = 0, pass_at = 1;
  logic [7:0] logw [0:31];
  logic [5:0] logv [0:31];
  logic       logn [0:31];

  always #2 clk = ~clk;  // 250 MHz

  wv_seq u_wv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_set(op_set), .accel(accel),
    .init_code(init_code), .pulse_valid(pulse_valid), .pulse_ready(pulse_ready),
    .pulse_volt(pulse_volt), .pulse_neg(pulse_neg), .pulse_width(pulse_width),
    .read_valid(read_valid), .read_ready(read_ready), .cmp_valid(cmp_valid),
    .cmp_ready(cmp_ready), .cmp_pass(cmp_pass), .done(done), .trials(trials),
    .total_width(total_width), .fail(fail)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver / sense / comparator responder with varying stalls
  initial begin
    pulse_ready = 1'b0; read_ready = 1'b0; cmp_valid = 1'b0; cmp_pass = 1'b0;
    forever begin
      @(negedge clk);
      if (pulse_valid) begin
        if (pcount < 32) begin
          logw[pcount] = pulse_width; logv[pcount] = pulse_volt; logn[pcount] = pulse_neg;
        end
        repeat (pcount % 3) @(negedge clk);
        pulse_ready = 1'b1;
        @(negedge clk);
        pulse_ready = 1'b0;
        pcount++;
      end else if (read_valid) begin
        repeat ((pcount + 1) % 2) @(negedge clk);
        read_ready = 1'b1;
        @(negedge clk);
        read_ready = 1'b0;
        rcount++;
      end else if (cmp_ready) begin
        cmp_pass  = (pcount >= pass_at);
        cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
      end
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done, "R7 done timeout", int'(done), 1);
  endtask

  // one operation, checked against a model of the requirements
  task automatic run(input string name, input bit s, input bit a, input int init,
                     input int pass_n, input bit poke);
    int expn, w, v, tot;
    bit expf;
    pass_at = pass_n; pcount = 0; rcount = 0;
    @(negedge clk);
    op_set = s; accel = a; init_code = 8'(init); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R11: second start while busy
      repeat (3) @(negedge clk);
      start = 1'b1; op_set = ~s; init_code = 8'd99;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    expn = (pass_n > 21) ? 21 : pass_n;
    expf = (pass_n > 21);
    w = s ? 5 : init;
    v = s ? (init % 64) : 15;
    tot = 0;
    for (int k = 1; k <= expn; k++) begin
      if (k > 1) begin
        if (s) v = (v + 1 > 63) ? 63 : v + 1;
        else   w = (w + (a ? 2 * (k - 1) : 2) > 255) ? 255 : w + (a ? 2 * (k - 1) : 2);
      end
      tot = (tot + w > 4095) ? 4095 : tot + w;
      if (s) begin
        check(logw[k-1] == 8'(w), {name, " R5 set width"}, logw[k-1], w);
        check(logv[k-1] == 6'(v), {name, " R5/R10 set volt"}, logv[k-1], v);
        check(logn[k-1] == 1'b0, {name, " R5 set polarity"}, logn[k-1], 0);
      end else begin
        check(logw[k-1] == 8'(w), {name, a ? " R4/R10 accel width" : " R3 linear width"}, logw[k-1], w);
        check(logv[k-1] == 6'd15, {name, " R2 reset volt"}, logv[k-1], 15);
        check(logn[k-1] == 1'b1, {name, " R2 reset polarity"}, logn[k-1], 1);
      end
    end
    check(trials == 5'(expn), {name, " R7 trials"}, trials, expn);
    check(fail == expf, {name, " R8 fail"}, fail, expf);
    check(pcount == expn, {name, " R8/R11 pulse count"}, pcount, expn);
    check(rcount == expn, {name, " R6 read count"}, rcount, expn);
    check(total_width == 12'(tot), {name, " R9 total"}, total_width, tot);
    @(negedge clk);
    check(!done, {name, " R7 done one cycle"}, done, 0);
    // R12: results hold while idle
    repeat (6) @(negedge clk);
    check(trials == 5'(expn) && fail == expf && total_width == 12'(tot) && !pulse_valid,
          {name, " R12 hold"}, total_width, tot);
  endtask

  task automatic t_reset_state();
    check(!done && !fail && !pulse_valid && !read_valid && !cmp_ready,
          "R1 idle flags", {done, fail, pulse_valid, read_valid, cmp_ready}, 0);
    check(trials == 0 && total_width == 0, "R1 counters", total_width, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    run("lin4",   1'b0, 1'b0, 10, 4, 1'b0);
    run("acc5",   1'b0, 1'b1, 10, 5, 1'b0);
    run("set3",   1'b1, 1'b0, 20, 3, 1'b0);
    run("first",  1'b0, 1'b0, 7, 1, 1'b0);
    run("limit",  1'b0, 1'b0, 1, 99, 1'b0);
    run("wsat",   1'b0, 1'b1, 250, 99, 1'b0);
    run("vsat",   1'b1, 1'b0, 62, 3, 1'b0);
    run("busy",   1'b0, 1'b1, 30, 5, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end
endmodule